// File: doc/BRIEF.md
# Floppy Rate Select and Disk Status Port

This block holds the data-rate and disk-status pair of a PC-compatible floppy controller. Both share one I/O offset. A write at that offset lands in a write-only rate-control register. That register holds a two-bit data-rate code and a no-precompensation flag.

A read at the same offset returns a status byte, and its layout follows the interface-mode input. In PS/2 style the byte carries a density flag, the rate code and a block of ones. In Model 30 style it carries the rate code, the precompensation flag, the DMA-enable flag from the neighbouring output register and a block of zeros. In both styles the top bit reports disk change. That bit is the inverted, synchronized cable level ORed with a force input.

The rate code is also driven out continuously, so the clock-select logic can use it directly. A hardware reset returns the code to 250 Kbps. A software reset leaves both stored fields alone.

Top module: `fdc_rate_status`

## Requirements
- R1: While hardware reset (`hw_rst_n` low) is asserted, and after it, before any write, `rate_code` is 2'b10 (250 Kbps) and the stored no-precompensation flag is 0. The rate encoding is 00 = 500 Kbps, 01 = 300 Kbps, 10 = 250 Kbps and 11 = 1 Mbps.
- R2: A write strobe with `io_addr` equal to `PORT_ADDR` stores `wdata[1:0]` as the rate code and `wdata[2]` as the no-precompensation flag, both visible from the next clock. `wdata[7:3]` are ignored. A write at any other address changes nothing.
- R3: While `sw_rst` is high, writes are ignored, and the rate code and no-precompensation flag keep their values.
- R4: On a read hit with `mode_m30` low, the status byte has this layout: bit 0 is 0 for codes 00 and 11 and 1 for codes 01 and 10; bits 2:1 hold the rate code; bits 6:3 read 1.
- R5: On a read hit with `mode_m30` high, the status byte has this layout: bits 1:0 hold the rate code; bit 2 holds the stored no-precompensation flag; bit 3 equals `dma_en`; bits 6:4 read 0.
- R6: Status bit 7 is `force_chg` ORed with the inverse of `disk_chg_pin`, where the pin goes through two flops first. A pin change shows in bit 7 after the second rising edge. `force_chg` acts at once.
- R7: Without a read hit, `rdata` is 8'h00. A read changes no stored state.
- R8: `rate_code` always equals the stored rate code, with no read needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hw_rst_n | input | 1 | Hardware reset, active low, asynchronous |
| sw_rst | input | 1 | Software reset, active high |
| io_addr | input | ADDR_W | I/O address |
| rd_stb | input | 1 | Read strobe |
| wr_stb | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, 0 without a read hit |
| disk_chg_pin | input | 1 | Disk-change level from the cable |
| force_chg | input | 1 | Force disk-change indication |
| dma_en | input | 1 | DMA-enable bit from the output register |
| mode_m30 | input | 1 | 1 = Model 30 layout, 0 = PS/2 layout |
| rate_code | output | 2 | Current data-rate code |

## Verification
On every cycle, the assertions check the following:
- the fixed fill bits and field placement of both read layouts;
- the zero bus when there is no read hit;
- that the rate code holds when there is no accepted write;
- that an accepted write lands on the next cycle.

Only the bench scenarios can show the following:
- the hardware reset value;
- software reset blocking writes and leaving the fields intact;
- that reads and mismatched addresses leave nothing changed;
- the two-cycle delay of the disk-change pin against the immediate force input.

// File: rtl/fdc_rate_status.sv
module fdc_rate_status #(
  parameter int ADDR_W = 3,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 3'h7
) (
  input  logic              clk,
  input  logic              hw_rst_n,
  input  logic              sw_rst,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              rd_stb,
  input  logic              wr_stb,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic              disk_chg_pin,
  input  logic              force_chg,
  input  logic              dma_en,
  input  logic              mode_m30,
  output logic [1:0]        rate_code
);
  localparam logic [1:0] RATE_250K = 2'b10;

  logic       hit, wr_ok, rd_ok;
  logic [1:0] rate_q;
  logic       noprec_q;
  logic       pin_s1, pin_s2;
  logic       chg_bit, dens;
  logic [7:0] ps2_view, m30_view;

  assign hit   = (io_addr == PORT_ADDR);
  assign wr_ok = wr_stb && hit && !sw_rst;
  assign rd_ok = rd_stb && hit;

  always_ff @(posedge clk or negedge hw_rst_n)
    if (!hw_rst_n) begin
      rate_q   <= RATE_250K;
      noprec_q <= 1'b0;
    end else if (wr_ok) begin
      rate_q   <= wdata[1:0];
      noprec_q <= wdata[2];
    end

  always_ff @(posedge clk or negedge hw_rst_n)
    if (!hw_rst_n) begin
      pin_s1 <= 1'b0;
      pin_s2 <= 1'b0;
    end else begin
      pin_s1 <= disk_chg_pin;
      pin_s2 <= pin_s1;
    end

  assign chg_bit   = force_chg | ~pin_s2;
  assign dens      = rate_q[1] ^ rate_q[0];
  assign ps2_view  = {chg_bit, 4'b1111, rate_q, dens};
  assign m30_view  = {chg_bit, 3'b000, dma_en, noprec_q, rate_q};
  assign rdata     = rd_ok ? (mode_m30 ? m30_view : ps2_view) : 8'h00;
  assign rate_code = rate_q;

  p_ps2_layout_r4: assert property (@(posedge clk) disable iff (!hw_rst_n)
    (rd_ok && !mode_m30) |-> (rdata[6:3] == 4'hF && rdata[2:1] == rate_code));
  p_m30_layout_r5: assert property (@(posedge clk) disable iff (!hw_rst_n)
    (rd_ok && mode_m30) |-> (rdata[6:4] == 3'b000 && rdata[3] == dma_en && rdata[1:0] == rate_code));
  p_idle_bus_r7: assert property (@(posedge clk) disable iff (!hw_rst_n)
    !rd_ok |-> (rdata == 8'h00));
  p_rate_hold_r3: assert property (@(posedge clk) disable iff (!hw_rst_n)
    !(wr_stb && hit && !sw_rst) |=> $stable(rate_code));
  p_write_lands_r2: assert property (@(posedge clk) disable iff (!hw_rst_n)
    (wr_stb && hit && !sw_rst) |=> (rate_code == $past(wdata[1:0])));
  p_force_wins_r6: assert property (@(posedge clk) disable iff (!hw_rst_n)
    (rd_ok && force_chg) |-> rdata[7]);
endmodule

// File: tb/test_fdc_rate_status.sv
module test_fdc_rate_status;
  logic clk = 0, hw_rst_n = 0, sw_rst = 0, rd_stb = 0, wr_stb = 0;
  logic [2:0] io_addr = 3'h7;
  logic [7:0] wdata = 0, rdata;
  logic disk_chg_pin = 1, force_chg = 0, dma_en = 0, mode_m30 = 0;
  logic [1:0] rate_code;
  int checks = 0, errors = 0;
  bit done = 0;

  fdc_rate_status i_fdc_rate_status (.*);

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); io_addr = a; wdata = d; wr_stb = 1;
    @(negedge clk); wr_stb = 0; io_addr = 3'h7;
  endtask

  task automatic rd(output logic [7:0] d);
    @(negedge clk); rd_stb = 1; #1 d = rdata;
    @(negedge clk); rd_stb = 0;
  endtask

  function automatic logic [7:0] ps2(input logic [1:0] r, input logic c);
    return {c, 4'hF, r, r[1] ^ r[0]};
  endfunction

  function automatic logic [7:0] m30(input logic [1:0] r, input logic np, input logic dm, input logic c);
    return {c, 3'b000, dm, np, r};
  endfunction

  task automatic t_reset;
    logic [7:0] d;
    chk("R1 rate in reset", {6'b0, rate_code}, 8'h02);
    @(negedge clk); hw_rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R1 rate after reset", {6'b0, rate_code}, 8'h02);
    mode_m30 = 1; rd(d);
    chk("R1 m30 view after reset", d, m30(2'b10, 0, 0, 0));
    mode_m30 = 0;
  endtask

  task automatic t_write_ps2;
    logic [7:0] d;
    for (int r = 0; r < 4; r++) begin
      wr(3'h7, {5'b11111, 1'b0, r[1:0]});
      chk("R8 rate port", {6'b0, rate_code}, {6'b0, r[1:0]});
      rd(d);
      chk("R4 ps2 view", d, ps2(r[1:0], 0));
    end
  endtask

  task automatic t_m30;
    logic [7:0] d;
    mode_m30 = 1; dma_en = 1;
    wr(3'h7, 8'hF5);
    rd(d); chk("R5 m30 view np=1 dma=1", d, m30(2'b01, 1, 1, 0));
    dma_en = 0; rd(d); chk("R5 m30 view dma=0", d, m30(2'b01, 1, 0, 0));
    wr(3'h7, 8'h03);
    rd(d); chk("R5 m30 view np=0", d, m30(2'b11, 0, 0, 0));
    mode_m30 = 0;
  endtask

  task automatic t_addr_and_bus;
    logic [7:0] d;
    wr(3'h3, 8'h06);
    chk("R2 other address ignored", {6'b0, rate_code}, 8'h03);
    @(negedge clk); io_addr = 3'h7; #1;
    chk("R7 idle bus", rdata, 8'h00);
    @(negedge clk); rd_stb = 1; io_addr = 3'h6; #1;
    chk("R7 read miss bus", rdata, 8'h00);
    @(negedge clk); rd_stb = 0; io_addr = 3'h7;
    repeat (3) rd(d);
    chk("R7 read no side effect", {6'b0, rate_code}, 8'h03);
  endtask

  task automatic t_sw_reset;
    logic [7:0] d;
    wr(3'h7, 8'h05);
    @(negedge clk); sw_rst = 1;
    @(negedge clk); io_addr = 3'h7; wdata = 8'h02; wr_stb = 1;
    @(negedge clk); wr_stb = 0; sw_rst = 0;
    chk("R3 write blocked in sw reset", {6'b0, rate_code}, 8'h01);
    mode_m30 = 1; rd(d);
    chk("R3 noprec kept through sw reset", d, m30(2'b01, 1, 0, 0));
    mode_m30 = 0;
  endtask

  task automatic t_disk_chg;
    logic [7:0] d;
    @(negedge clk); rd_stb = 1; disk_chg_pin = 0;
    @(negedge clk); #1 chk("R6 pin after one edge", {7'b0, rdata[7]}, 8'h00);
    @(negedge clk); #1 chk("R6 pin after two edges", {7'b0, rdata[7]}, 8'h01);
    disk_chg_pin = 1;
    repeat (2) @(negedge clk);
    #1 chk("R6 pin high clears", {7'b0, rdata[7]}, 8'h00);
    force_chg = 1; #1 chk("R6 force immediate", {7'b0, rdata[7]}, 8'h01);
    @(negedge clk); rd_stb = 0; force_chg = 0;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    t_reset;
    t_write_ps2;
    t_m30;
    t_addr_and_bus;
    t_sw_reset;
    t_disk_chg;
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule